// File: doc/BRIEF.md
# Dual-Stack Zero-Operand Processor Core

This core executes a compact byte-coded program in which arithmetic, memory and branch instructions find their operands on a data stack instead of in named registers. A second, narrower stack holds only return addresses. A subroutine call therefore touches the return stack alone, and the computation stack is handed to the callee unchanged. The architectural state is a program counter, the two stacks and their depth counters.

The core fetches one opcode byte per instruction from an instruction memory with a combinational read. The literal, jump, jump-if-zero and call instructions fetch one more byte, which holds an immediate value or a target. Loads and stores go to a word-wide data memory, also read combinationally and written on the clock edge. If an instruction would pop more entries than a stack holds, or push past its capacity, the core leaves both stacks untouched, raises a sticky flag and stops. The flags clear only on reset.

An instruction with no argument byte takes two cycles (fetch, execute). An instruction with an argument byte takes three (fetch, argument, execute). The top of the data stack and both depths are visible at the ports, so software-free debug and test can observe the machine state.

Top module: `stackcore_top`

## Requirements
- R1: While reset is high and in the first cycle after it falls, the program counter (imem_addr) is 0, both stack depths are 0, halted is 0 and both error flags are 0.
- R2: Opcode 0x01 (literal) takes the next byte as an immediate. It pushes that byte zero-extended to the data width, and execution continues two bytes after the opcode.
- R3: Opcode 0x02 pops TOP and NEXT and pushes NEXT+TOP. Opcode 0x03 pops them and pushes NEXT-TOP. Both results wrap modulo 2^16, so the depth falls by one.
- R4: Opcode 0x04 (load) pops an address and pushes the data memory word at that address.
- R5: Opcode 0x05 (store) writes NEXT to the data memory at address TOP in a single write and pops both entries.
- R6: Opcode 0x06 (jump-if-zero) has a one-byte target. It pops TOP and jumps to the target when the popped value is zero. Otherwise execution continues after the target byte.
- R7: Opcode 0x07 (call) has a one-byte target. It pushes the address after its target byte onto the return stack and jumps. Opcode 0x08 (return) pops the return stack into the program counter. Neither one changes the data stack.
- R8: Opcode 0x09 jumps unconditionally to its one-byte target. Opcode 0x0B duplicates TOP. Opcode 0x0C discards TOP. Opcode 0x00 does nothing.
- R9: A push to a full stack (16 data entries or 8 return entries) sets ovf_flag and halts the core. The stack keeps its previous depth and contents, and the flag and halt persist until reset.
- R10: An instruction that needs more data-stack entries than are present, or a return with an empty return stack, sets unf_flag and halts the core with no stack change.
- R11: Opcode 0x0A halts the core with the program counter one past the halt opcode. Any opcode value not listed in R2 to R10 executes as a no-operation.
- R12: An instruction that pops and pushes in the same cycle (add or subtract on a full data stack) completes normally and does not raise ovf_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 8 | Instruction byte address (program counter) |
| imem_data | input | 8 | Instruction byte at imem_addr |
| dmem_addr | output | DAW | Data memory word address (taken from TOP) |
| dmem_we | output | 1 | Data memory write strobe |
| dmem_wdata | output | DW | Data memory write word (NEXT) |
| dmem_rdata | input | DW | Data memory word at dmem_addr |
| tos | output | DW | Current top of the data stack |
| dstk_depth | output | clog2(DDEPTH+1) | Data stack entry count |
| cstk_depth | output | clog2(CDEPTH+1) | Return stack entry count |
| halted | output | 1 | Core has stopped |
| ovf_flag | output | 1 | Sticky stack overflow flag |
| unf_flag | output | 1 | Sticky stack underflow flag |

## Verification
A binary operation on a completely full data stack pops two entries and pushes one in a single cycle. The pop and the push therefore share one write into the LIFO, and a check that looked only at the push would report a false overflow. The bench fills the stack with sixteen literals and then issues an add. It judges the result from the final depth of 15, the sum of the two top literals and a clear overflow flag. For contrast, a seventeenth literal on a full stack must raise the flag and leave the depth at 16. A store likewise combines a memory write with a double pop in one cycle. The bench checks the written word, the untouched neighbouring word and the depth after the pop.

// File: rtl/stackcore_pkg.sv
package stackcore_pkg;

    localparam int PC_W  = 8;
    localparam int OPC_W = 8;

    typedef enum logic [OPC_W-1:0] {
        OP_NOP   = 8'h00,
        OP_LIT   = 8'h01,
        OP_ADD   = 8'h02,
        OP_SUB   = 8'h03,
        OP_LOAD  = 8'h04,
        OP_STORE = 8'h05,
        OP_JZ    = 8'h06,
        OP_CALL  = 8'h07,
        OP_RET   = 8'h08,
        OP_JMP   = 8'h09,
        OP_HALT  = 8'h0A,
        OP_DUP   = 8'h0B,
        OP_DROP  = 8'h0C
    } opcode_e;

    typedef enum logic [1:0] {
        PH_FETCH,
        PH_ARG,
        PH_EXEC,
        PH_STOP
    } phase_e;

    typedef enum logic [1:0] {
        FL_SEQ,
        FL_JUMP,
        FL_JZ,
        FL_RET
    } flow_e;

    typedef enum logic [2:0] {
        AL_IMM,
        AL_ADD,
        AL_SUB,
        AL_MEM,
        AL_TOP
    } alu_e;

    // Per-opcode control word
    typedef struct packed {
        logic       has_arg;  // one inline byte follows
        logic [1:0] d_need;   // data entries that must be present
        logic [1:0] d_pop;    // data entries removed
        logic       d_push;   // one data entry written
        logic       c_pop;    // return stack pop
        logic       c_push;   // return stack push
        logic       mem_wr;   // data memory write
        logic       stop;     // halt opcode
        flow_e      flow;
        alu_e       alu;
    } dec_t;

    function automatic dec_t dec_idle();
        dec_t d;
        d.has_arg = 1'b0;
        d.d_need  = 2'd0;
        d.d_pop   = 2'd0;
        d.d_push  = 1'b0;
        d.c_pop   = 1'b0;
        d.c_push  = 1'b0;
        d.mem_wr  = 1'b0;
        d.stop    = 1'b0;
        d.flow    = FL_SEQ;
        d.alu     = AL_IMM;
        return d;
    endfunction

endpackage

// File: rtl/stackcore_decode.sv
module stackcore_decode
    import stackcore_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output dec_t             dec
);

    always_comb begin
        dec = dec_idle();
        case (opcode)
            OP_LIT: begin
                dec.has_arg = 1'b1;
                dec.d_push  = 1'b1;
                dec.alu     = AL_IMM;
            end
            OP_ADD: begin
                dec.d_need = 2'd2;
                dec.d_pop  = 2'd2;
                dec.d_push = 1'b1;
                dec.alu    = AL_ADD;
            end
            OP_SUB: begin
                dec.d_need = 2'd2;
                dec.d_pop  = 2'd2;
                dec.d_push = 1'b1;
                dec.alu    = AL_SUB;
            end
            OP_LOAD: begin
                dec.d_need = 2'd1;
                dec.d_pop  = 2'd1;
                dec.d_push = 1'b1;
                dec.alu    = AL_MEM;
            end
            OP_STORE: begin
                dec.d_need = 2'd2;
                dec.d_pop  = 2'd2;
                dec.mem_wr = 1'b1;
            end
            OP_JZ: begin
                dec.has_arg = 1'b1;
                dec.d_need  = 2'd1;
                dec.d_pop   = 2'd1;
                dec.flow    = FL_JZ;
            end
            OP_CALL: begin
                dec.has_arg = 1'b1;
                dec.c_push  = 1'b1;
                dec.flow    = FL_JUMP;
            end
            OP_RET: begin
                dec.c_pop = 1'b1;
                dec.flow  = FL_RET;
            end
            OP_JMP: begin
                dec.has_arg = 1'b1;
                dec.flow    = FL_JUMP;
            end
            OP_HALT: begin
                dec.stop = 1'b1;
            end
            OP_DUP: begin
                dec.d_need = 2'd1;
                dec.d_push = 1'b1;
                dec.alu    = AL_TOP;
            end
            OP_DROP: begin
                dec.d_need = 2'd1;
                dec.d_pop  = 2'd1;
            end
            default: dec = dec_idle();
        endcase
    end

endmodule

// File: rtl/stackcore_alu.sv
module stackcore_alu
    import stackcore_pkg::*;
#(
    parameter int DW = 16
) (
    input  alu_e            sel,
    input  logic [DW-1:0]   top,
    input  logic [DW-1:0]   next,
    input  logic [7:0]      imm,
    input  logic [DW-1:0]   mem,
    output logic [DW-1:0]   result
);

    always_comb begin
        case (sel)
            AL_IMM:  result = DW'(imm);
            AL_ADD:  result = next + top;
            AL_SUB:  result = next - top;
            AL_MEM:  result = mem;
            AL_TOP:  result = top;
            default: result = '0;
        endcase
    end

endmodule

// File: rtl/stackcore_lifo.sv
module stackcore_lifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [1:0]                 pop_n,
    input  logic                       push,
    input  logic [WIDTH-1:0]           wdata,
    output logic [WIDTH-1:0]           top,
    output logic [WIDTH-1:0]           next,
    output logic [$clog2(DEPTH+1)-1:0] depth
);

    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [CW-1:0]    after_pop;

    // Pop and push share one write slot: the push lands where the pops leave off
    assign after_pop = depth - CW'(pop_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            depth <= '0;
        end else begin
            depth <= after_pop + CW'(push);
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem[IW'(after_pop)] <= wdata;
        end
    end

    assign top  = mem[IW'(depth - CW'(1))];
    assign next = mem[IW'(depth - CW'(2))];

endmodule

// File: rtl/stackcore_top.sv
module stackcore_top
    import stackcore_pkg::*;
#(
    parameter int DDEPTH = 16,
    parameter int CDEPTH = 8,
    parameter int DW     = 16,
    parameter int DAW    = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    output logic [PC_W-1:0]             imem_addr,
    input  logic [OPC_W-1:0]            imem_data,
    output logic [DAW-1:0]              dmem_addr,
    output logic                        dmem_we,
    output logic [DW-1:0]               dmem_wdata,
    input  logic [DW-1:0]               dmem_rdata,
    output logic [DW-1:0]               tos,
    output logic [$clog2(DDEPTH+1)-1:0] dstk_depth,
    output logic [$clog2(CDEPTH+1)-1:0] cstk_depth,
    output logic                        halted,
    output logic                        ovf_flag,
    output logic                        unf_flag
);

    localparam int DCW = $clog2(DDEPTH+1);
    localparam int CCW = $clog2(CDEPTH+1);

    phase_e          state;
    logic [PC_W-1:0] pc;
    logic [7:0]      ir;
    logic [7:0]      arg;

    logic [7:0]      dec_byte;
    dec_t            dec;

    logic [DW-1:0]   d_top, d_next, alu_out;
    logic [PC_W-1:0] c_top, c_next;

    logic [DCW:0]    d_after;
    logic            d_unf, c_unf, d_ovf, c_ovf;
    logic            in_exec, unf_hit, ovf_hit, exec_ok;

    logic [1:0]      d_pop_n, c_pop_n;
    logic            d_push_en, c_push_en;

    // Decode the incoming byte during fetch, the held opcode afterwards
    assign dec_byte = (state == PH_FETCH) ? imem_data : ir;

    stackcore_decode u_dec (
        .opcode (dec_byte),
        .dec    (dec)
    );

    stackcore_alu #(.DW(DW)) u_alu (
        .sel    (dec.alu),
        .top    (d_top),
        .next   (d_next),
        .imm    (arg),
        .mem    (dmem_rdata),
        .result (alu_out)
    );

    // Stack bounds are judged on the net effect of the instruction
    assign d_after = {1'b0, dstk_depth} - (DCW+1)'(dec.d_pop) + (DCW+1)'(dec.d_push);
    assign d_unf   = dstk_depth < DCW'(dec.d_need);
    assign c_unf   = dec.c_pop && (cstk_depth == '0);
    assign d_ovf   = d_after > (DCW+1)'(DDEPTH);
    assign c_ovf   = dec.c_push && (cstk_depth == CCW'(CDEPTH));

    assign in_exec = (state == PH_EXEC);
    assign unf_hit = in_exec && (d_unf || c_unf);
    assign ovf_hit = in_exec && !(d_unf || c_unf) && (d_ovf || c_ovf);
    assign exec_ok = in_exec && !unf_hit && !ovf_hit;

    assign d_pop_n   = exec_ok ? dec.d_pop : 2'd0;
    assign d_push_en = exec_ok && dec.d_push;
    assign c_pop_n   = {1'b0, exec_ok && dec.c_pop};
    assign c_push_en = exec_ok && dec.c_push;

    stackcore_lifo #(.DEPTH(DDEPTH), .WIDTH(DW)) u_dstk (
        .clk   (clk),
        .rst   (rst),
        .pop_n (d_pop_n),
        .push  (d_push_en),
        .wdata (alu_out),
        .top   (d_top),
        .next  (d_next),
        .depth (dstk_depth)
    );

    // Return stack: pc already points past the argument when a call executes
    stackcore_lifo #(.DEPTH(CDEPTH), .WIDTH(PC_W)) u_cstk (
        .clk   (clk),
        .rst   (rst),
        .pop_n (c_pop_n),
        .push  (c_push_en),
        .wdata (pc),
        .top   (c_top),
        .next  (c_next),
        .depth (cstk_depth)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= PH_FETCH;
            pc       <= '0;
            ir       <= '0;
            arg      <= '0;
            ovf_flag <= 1'b0;
            unf_flag <= 1'b0;
        end else begin
            case (state)
                PH_FETCH: begin
                    ir    <= imem_data;
                    pc    <= pc + PC_W'(1);
                    state <= dec.has_arg ? PH_ARG : PH_EXEC;
                end
                PH_ARG: begin
                    arg   <= imem_data;
                    pc    <= pc + PC_W'(1);
                    state <= PH_EXEC;
                end
                PH_EXEC: begin
                    if (unf_hit) begin
                        unf_flag <= 1'b1;
                        state    <= PH_STOP;
                    end else if (ovf_hit) begin
                        ovf_flag <= 1'b1;
                        state    <= PH_STOP;
                    end else begin
                        case (dec.flow)
                            FL_JUMP: pc <= arg;
                            FL_JZ:   if (d_top == '0) pc <= arg;
                            FL_RET:  pc <= c_top;
                            default: pc <= pc;
                        endcase
                        state <= dec.stop ? PH_STOP : PH_FETCH;
                    end
                end
                default: state <= PH_STOP;
            endcase
        end
    end

    assign imem_addr  = pc;
    assign dmem_addr  = d_top[DAW-1:0];
    assign dmem_wdata = d_next;
    assign dmem_we    = exec_ok && dec.mem_wr;
    assign tos        = d_top;
    assign halted     = (state == PH_STOP);

endmodule

// File: rtl/stackcore_chk.sv
module stackcore_chk
    import stackcore_pkg::*;
#(
    parameter int DDEPTH = 16,
    parameter int CDEPTH = 8
) (
    input logic                        clk,
    input logic                        rst,
    input phase_e                      state,
    input logic [7:0]                  ir,
    input logic                        exec_ok,
    input logic                        dmem_we,
    input logic [$clog2(DDEPTH+1)-1:0] dstk_depth,
    input logic [$clog2(CDEPTH+1)-1:0] cstk_depth,
    input logic                        halted,
    input logic                        ovf_flag,
    input logic                        unf_flag
);

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (dstk_depth == '0 && cstk_depth == '0 && !halted && !ovf_flag && !unf_flag));

    p_arith_shrinks_r3: assert property (@(posedge clk) disable iff (rst)
        (exec_ok && (ir == OP_ADD || ir == OP_SUB)) |=> (dstk_depth == $past(dstk_depth) - 1'b1));

    p_write_needs_two_r5: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> (dstk_depth >= 2 && state == PH_EXEC));

    p_store_pops_two_r5: assert property (@(posedge clk) disable iff (rst)
        (exec_ok && ir == OP_STORE) |=> (dstk_depth == $past(dstk_depth) - 2'd2));

    p_call_keeps_data_r7: assert property (@(posedge clk) disable iff (rst)
        (exec_ok && (ir == OP_CALL || ir == OP_RET)) |=> $stable(dstk_depth));

    p_depth_bound_r9: assert property (@(posedge clk) disable iff (rst)
        (dstk_depth <= DDEPTH && cstk_depth <= CDEPTH));

    p_halt_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && $stable(dstk_depth) && $stable(cstk_depth)));

    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag || unf_flag) |-> halted);

    p_no_write_stopped_r10: assert property (@(posedge clk) disable iff (rst)
        halted |-> !dmem_we);

endmodule

bind stackcore_top stackcore_chk #(
    .DDEPTH (DDEPTH),
    .CDEPTH (CDEPTH)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .state      (state),
    .ir         (ir),
    .exec_ok    (exec_ok),
    .dmem_we    (dmem_we),
    .dstk_depth (dstk_depth),
    .cstk_depth (cstk_depth),
    .halted     (halted),
    .ovf_flag   (ovf_flag),
    .unf_flag   (unf_flag)
);

// File: tb/sim_stackcore_top.sv
module sim_stackcore_top;

    localparam int CLK_PERIOD = 10;
    localparam int RUN_LIMIT  = 3000;

    localparam logic [7:0] C_NOP = 8'h00, C_LIT = 8'h01, C_ADD = 8'h02, C_SUB = 8'h03,
                           C_LD  = 8'h04, C_ST  = 8'h05, C_JZ  = 8'h06, C_CALL = 8'h07,
                           C_RET = 8'h08, C_JMP = 8'h09, C_HLT = 8'h0A, C_DUP = 8'h0B,
                           C_DRP = 8'h0C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  imem_addr, imem_data;
    logic [7:0]  dmem_addr;
    logic        dmem_we;
    logic [15:0] dmem_wdata, dmem_rdata;
    logic [15:0] tos;
    logic [4:0]  dstk_depth;
    logic [3:0]  cstk_depth;
    logic        halted, ovf_flag, unf_flag;

    logic [7:0]  imem [256];
    logic [15:0] dmem [256];

    int n_tests = 0;
    int n_fail  = 0;
    int wp      = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign imem_data  = imem[imem_addr];
    assign dmem_rdata = dmem[dmem_addr];

    always @(posedge clk) begin
        if (dmem_we) dmem[dmem_addr] <= dmem_wdata;
    end

    stackcore_top u0 (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_data  (imem_data),
        .dmem_addr  (dmem_addr),
        .dmem_we    (dmem_we),
        .dmem_wdata (dmem_wdata),
        .dmem_rdata (dmem_rdata),
        .tos        (tos),
        .dstk_depth (dstk_depth),
        .cstk_depth (cstk_depth),
        .halted     (halted),
        .ovf_flag   (ovf_flag),
        .unf_flag   (unf_flag)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic fresh();
        for (int i = 0; i < 256; i++) begin
            imem[i] = C_HLT;
            dmem[i] = '0;
        end
        wp = 0;
    endtask

    task automatic emit(input logic [7:0] b);
        imem[wp] = b;
        wp++;
    endtask

    task automatic lit(input logic [7:0] v);
        emit(C_LIT);
        emit(v);
    endtask

    task automatic run(input string tag);
        int cyc;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cyc = 0;
        while (!halted && cyc < RUN_LIMIT) begin
            @(negedge clk);
            cyc++;
        end
        chk({tag, " run reaches halt"}, {31'd0, halted}, 32'd1);
    endtask

    task automatic ends(input string tag, input int depth, input logic [15:0] top,
                        input int cdepth, input logic ovf, input logic unf);
        chk({tag, " data depth"}, 32'(dstk_depth), 32'(depth));
        if (depth > 0) chk({tag, " top value"}, 32'(tos), 32'(top));
        chk({tag, " return depth"}, 32'(cstk_depth), 32'(cdepth));
        chk({tag, " ovf flag"}, {31'd0, ovf_flag}, {31'd0, ovf});
        chk({tag, " unf flag"}, {31'd0, unf_flag}, {31'd0, unf});
    endtask

    // Reference model for random arithmetic programs
    logic [15:0] ms [16];
    int          md;

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual expired expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd4242);

        // R1: reset state
        fresh();
        lit(8'h11);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 pc in reset", 32'(imem_addr), 32'd0);
        chk("R1 depths in reset", {dstk_depth, cstk_depth}, 32'd0);
        chk("R1 halted/flags in reset", {halted, ovf_flag, unf_flag}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 pc after release fetch", 32'(imem_addr), 32'd1);

        // R2 / R11: literals then halt
        fresh();
        lit(8'hAB); lit(8'h05); emit(C_HLT);
        run("R2");
        ends("R2", 2, 16'h0005, 0, 0, 0);
        chk("R11 pc after halt", 32'(imem_addr), 32'd5);
        repeat (4) @(negedge clk);
        chk("R11 still halted", {31'd0, halted}, 32'd1);

        // R3: subtract order, wrap, add
        fresh();
        lit(8'd10); lit(8'd3); emit(C_SUB); emit(C_HLT);
        run("R3 sub");
        ends("R3 sub", 1, 16'd7, 0, 0, 0);
        fresh();
        lit(8'd2); lit(8'd5); emit(C_SUB); emit(C_HLT);
        run("R3 wrap");
        ends("R3 wrap", 1, 16'hFFFD, 0, 0, 0);
        fresh();
        lit(8'd200); lit(8'd100); emit(C_ADD); emit(C_HLT);
        run("R3 add");
        ends("R3 add", 1, 16'd300, 0, 0, 0);

        // R5 / R4: store then load back
        fresh();
        lit(8'h55); lit(8'h20); emit(C_ST); lit(8'h20); emit(C_LD); emit(C_HLT);
        run("R4");
        ends("R4 load", 1, 16'h0055, 0, 0, 0);
        chk("R5 stored word", 32'(dmem[8'h20]), 32'h55);
        chk("R5 neighbour untouched", 32'(dmem[8'h21]), 32'h0);
        fresh();
        lit(8'hFF); lit(8'hFF); emit(C_ADD); lit(8'h21); emit(C_ST); emit(C_HLT);
        run("R5");
        chk("R5 wide word", 32'(dmem[8'h21]), 32'h1FE);
        chk("R5 pops both", 32'(dstk_depth), 32'd0);

        // R6: jump-if-zero taken and not taken
        fresh();
        lit(8'd0); emit(C_JZ); emit(8'd7); lit(8'd1); emit(C_HLT); lit(8'd2); emit(C_HLT);
        run("R6 taken");
        ends("R6 taken", 1, 16'd2, 0, 0, 0);
        fresh();
        lit(8'd3); emit(C_JZ); emit(8'd7); lit(8'd1); emit(C_HLT); lit(8'd2); emit(C_HLT);
        run("R6 fall");
        ends("R6 fall", 1, 16'd1, 0, 0, 0);

        // R7: call and return leave data stack alone
        fresh();
        lit(8'd9); emit(C_CALL); emit(8'd6); emit(C_HLT); emit(C_NOP);
        lit(8'd4); emit(C_ADD); emit(C_RET);
        run("R7 call/ret");
        ends("R7 call/ret", 1, 16'd13, 0, 0, 0);
        chk("R7 return address", 32'(imem_addr), 32'd5);
        fresh();
        lit(8'd9); emit(C_CALL); emit(8'd6); emit(C_HLT); emit(C_NOP); emit(C_HLT);
        run("R7 inside");
        ends("R7 inside", 1, 16'd9, 1, 0, 0);

        // R8: jump, dup, drop, nop
        fresh();
        emit(C_JMP); emit(8'd4); lit(8'd99); lit(8'd7); emit(C_DUP); emit(C_ADD);
        lit(8'd5); emit(C_DRP); emit(C_NOP); emit(C_HLT);
        run("R8");
        ends("R8", 1, 16'd14, 0, 0, 0);

        // R11: unknown opcode is a no-op
        fresh();
        lit(8'd4); emit(8'hFF); emit(C_HLT);
        run("R11 unknown");
        ends("R11 unknown", 1, 16'd4, 0, 0, 0);
        chk("R11 pc after unknown", 32'(imem_addr), 32'd4);

        // R9: data overflow, then sticky
        fresh();
        for (int k = 1; k <= 17; k++) lit(8'(k));
        run("R9 data");
        ends("R9 data", 16, 16'd16, 0, 1, 0);
        repeat (10) @(negedge clk);
        chk("R9 sticky halt", {30'd0, halted, ovf_flag}, 32'd3);
        chk("R9 sticky depth", 32'(dstk_depth), 32'd16);

        // R9: return stack overflow by self call
        fresh();
        emit(C_CALL); emit(8'd0);
        run("R9 ret stack");
        ends("R9 ret stack", 0, 16'd0, 8, 1, 0);

        // R12: add on a full stack
        fresh();
        for (int k = 1; k <= 16; k++) lit(8'(k));
        emit(C_ADD); emit(C_HLT);
        run("R12");
        ends("R12", 15, 16'd31, 0, 0, 0);

        // R10: underflow cases
        fresh();
        lit(8'd1); emit(C_ADD);
        run("R10 add");
        ends("R10 add", 1, 16'd1, 0, 0, 1);
        fresh();
        emit(C_RET);
        run("R10 ret");
        ends("R10 ret", 0, 16'd0, 0, 0, 1);
        fresh();
        emit(C_DUP);
        run("R10 dup");
        ends("R10 dup", 0, 16'd0, 0, 0, 1);

        // R2/R3 random arithmetic programs against a bench model
        for (int t = 0; t < 24; t++) begin
            fresh();
            md = 0;
            for (int s = 0; s < 14; s++) begin
                int unsigned r;
                r = $urandom % 4;
                if (md < 2 || (r == 0 && md < 16)) begin
                    logic [7:0] v;
                    v = 8'($urandom);
                    lit(v);
                    ms[md] = 16'(v);
                    md++;
                end else if (r == 1) begin
                    emit(C_SUB);
                    ms[md-2] = ms[md-2] - ms[md-1];
                    md--;
                end else begin
                    emit(C_ADD);
                    ms[md-2] = ms[md-2] + ms[md-1];
                    md--;
                end
            end
            emit(C_HLT);
            run("R3 random");
            ends("R3 random", md, ms[md-1], 0, 0, 0);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule